// File: doc/BRIEF.md
# Wide register write collector

This block sits on the slave side of a host register bus that moves 32-bit or 64-bit words, in front of an internal register file whose registers are 128 bits wide and a buffer table whose entries are 64 bits wide. Narrow writes aimed at a wide register are gathered in a staging buffer. The target is updated in one step, through a single-cycle commit strobe, when the word at the top of the register arrives. Reads work the other way round. Reading the lowest word copies the whole register into a shadow, and the remaining words of that read are served from the shadow, so the host sees one consistent value.

Three designated registers are repeated in every 8 KiB page: an event-queue read pointer, a receive descriptor update and a transmit descriptor update. A single 32-bit write to one of them takes effect at once on a separate strobe and leaves the staging buffer alone. This lets those frequent updates run without the host holding a lock around the wide accesses. Every request carries a byte address and a size flag. Read data returns one cycle after the request.

Top module: `wreg_collector`

## Requirements
- R1: For a wide register (address MSB clear, outside the designated slots), dword writes at byte offsets 0, 4 and 8 only fill the staging buffer and raise no commit. A dword write at offset 12 raises `commit_o` for exactly the following cycle, with `commit_sram_o` low, `commit_index_o` = address bits [ADDR_W-2:4], and dword k of `commit_data_o` equal to the word written at offset 4k.
- R2: A 64-bit write at offset 0 stages dwords 0 and 1 (low half of the bus data in dword 0). A 64-bit write at offset 8 places the bus data in dwords 2 and 3 and commits.
- R3: Any word not written since the last commit or restart is committed as zero. A wide or SRAM write whose index or region differs from the open collection discards the staged words before it is applied.
- R4: A buffer-table entry (address MSB set, index = address bits [ADDR_W-2:3]) is staged by a dword at offset 0. It commits on a dword at offset 4 or on a 64-bit write at offset 0, with `commit_sram_o` high and bits [127:64] of the commit data zero.
- R5: Within every page (page = address bits [ADDR_W-2:PAGE_SHIFT]), the 16-byte slots at page offsets OFS_EVQ, OFS_RX and OFS_TX are designated registers, with codes 0, 1 and 2. A dword write at a slot base raises `dw_we_o` for one cycle in the next cycle, carrying that code, the page and the 32-bit data, and raises no commit.
- R6: A designated-register write that arrives between the words of an open wide collection leaves the staged words intact, and the later top-word write commits the full, correct value.
- R7: Writes with byte address bits [1:0] nonzero, 64-bit accesses with address bit 2 set, and accesses to a designated slot other than a dword at its base are ignored. They raise no strobe and leave the staging buffer unchanged.
- R8: A dword or 64-bit read at offset 0 of a wide register loads the 128-bit shadow from `rd_data_i`, where `rd_index_o` is the wide index and `rd_sram_o` is low. Dword reads at offsets 4, 8 and 12, and a 64-bit read at offset 8, return the shadow contents whatever the register holds at that moment.
- R9: If a shadow-loading read of a register arrives in the cycle where `commit_o` is high for that same register, the shadow takes `commit_data_o` in place of `rd_data_i`.
- R10: Every read raises `rd_valid_o` in the next cycle only. Buffer-table reads return the selected dword, or the 64-bit entry, taken directly from `rd_data_i`. Designated-register reads return `rd_data_i[31:0]`. Ignored reads return zero.
- R11: After reset `commit_o`, `dw_we_o` and `rd_valid_o` are low and `rd_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_qword_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 64 | Write data (dword accesses use bits [31:0]) |
| rd_index_o | output | IDX_W | Register-file read index for the current request |
| rd_sram_o | output | 1 | Read index selects the buffer table |
| rd_data_i | input | 128 | Current value of the addressed register or entry |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 64 | Read response data |
| commit_o | output | 1 | One-cycle commit strobe |
| commit_sram_o | output | 1 | Commit targets the buffer table |
| commit_index_o | output | IDX_W | Committed register or entry index |
| commit_data_o | output | 128 | Committed value |
| dw_we_o | output | 1 | Designated-register write strobe |
| dw_sel_o | output | 2 | Designated register code: 0 event pointer, 1 receive, 2 transmit |
| dw_page_o | output | PG_W | Page of the designated write |
| dw_data_o | output | 32 | Designated write data |

## Verification
Two overlaps need checking. The first is a commit strobe that is still on the outputs when the next request, a read of dword 0 of the same register, is captured. The bench issues that read right after the top-word write, puts the stale value on `rd_data_i` and expects the shadow to hold the value just committed. It then repeats the read against a different index, where the stale bus value must win. The second overlap is a designated-register write arriving inside an open wide collection. The bench interleaves such writes between wide words, checks each one on the dword strobe, and compares the final commit word by word against the pattern it computed itself.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  localparam int unsigned DW_W   = 32;
  localparam int unsigned WORDS  = 4;
  localparam int unsigned WIDE_W = DW_W * WORDS;

  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_WIDE  = 2'd1,
    RG_SRAM  = 2'd2,
    RG_DWREG = 2'd3
  } region_e;
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
  import wrc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned OFS_EVQ    = 'h400,
  parameter int unsigned OFS_RX     = 'h800,
  parameter int unsigned OFS_TX     = 'hC00,
  parameter int unsigned IDX_W      = ADDR_W - 4,
  parameter int unsigned PG_W       = ADDR_W - 1 - PAGE_SHIFT
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              qword_i,
  output region_e           region_o,
  output logic [1:0]        lane_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PG_W-1:0]   page_o,
  output logic [1:0]        dw_sel_o
);
  localparam int unsigned SLOT_W = PAGE_SHIFT - 4;
  localparam logic [SLOT_W-1:0] SLOT_EVQ = SLOT_W'(OFS_EVQ >> 4);
  localparam logic [SLOT_W-1:0] SLOT_RX  = SLOT_W'(OFS_RX >> 4);
  localparam logic [SLOT_W-1:0] SLOT_TX  = SLOT_W'(OFS_TX >> 4);

  logic              is_sram, dw_hit, misalign;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    is_sram = addr_i[ADDR_W-1];
    slot    = addr_i[PAGE_SHIFT-1:4];
    if (slot == SLOT_EVQ)      dw_sel_o = 2'd0;
    else if (slot == SLOT_RX)  dw_sel_o = 2'd1;
    else if (slot == SLOT_TX)  dw_sel_o = 2'd2;
    else                       dw_sel_o = 2'd3;
    dw_hit   = !is_sram && (dw_sel_o != 2'd3);
    misalign = (addr_i[1:0] != 2'b00) || (qword_i && addr_i[2]);
    idx_o    = is_sram ? addr_i[ADDR_W-2:3] : {1'b0, addr_i[ADDR_W-2:4]};
    lane_o   = is_sram ? {1'b0, addr_i[2]} : addr_i[3:2];
    page_o   = addr_i[ADDR_W-2:PAGE_SHIFT];
    if (misalign)     region_o = RG_NONE;
    else if (is_sram) region_o = RG_SRAM;
    else if (dw_hit)  region_o = (!qword_i && addr_i[3:2] == 2'd0) ? RG_DWREG : RG_NONE;
    else              region_o = RG_WIDE;
  end
endmodule

// File: rtl/wrc_stage.sv
module wrc_stage
  import wrc_pkg::*;
#(
  parameter int unsigned IDX_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sram_i,
  input  logic              qword_i,
  input  logic [1:0]        lane_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [63:0]       wdata_i,
  output logic              commit_o,
  output logic              commit_sram_o,
  output logic [IDX_W-1:0]  commit_index_o,
  output logic [WIDE_W-1:0] commit_data_o
);
  logic [WIDE_W-1:0] stage_q, merged;
  logic [WORDS-1:0]  vld_q, base, wmask;
  logic [IDX_W-1:0]  idx_q;
  logic              sram_q, same, last;
  logic [DW_W-1:0]   wword [WORDS];

  always_comb begin
    same  = (|vld_q) && (idx_q == idx_i) && (sram_q == sram_i);
    base  = same ? vld_q : '0;
    if (qword_i) wmask = lane_i[1] ? 4'b1100 : 4'b0011;
    else         wmask = 4'b0001 << lane_i;
    last  = sram_i ? (qword_i || lane_i[0])
                   : (qword_i ? lane_i[1] : (lane_i == 2'd3));
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign wword[w] = qword_i ? wdata_i[DW_W*(w%2) +: DW_W] : wdata_i[DW_W-1:0];
    assign merged[DW_W*w +: DW_W] = wmask[w] ? wword[w]
                                  : (base[w] ? stage_q[DW_W*w +: DW_W] : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q        <= '0;
      vld_q          <= '0;
      idx_q          <= '0;
      sram_q         <= 1'b0;
      commit_o       <= 1'b0;
      commit_sram_o  <= 1'b0;
      commit_index_o <= '0;
      commit_data_o  <= '0;
    end else begin
      commit_o <= wr_i && last;
      if (wr_i) begin
        if (last) begin
          vld_q          <= '0;
          commit_sram_o  <= sram_i;
          commit_index_o <= idx_i;
          commit_data_o  <= merged;
        end else begin
          stage_q <= merged;
          vld_q   <= base | wmask;
          idx_q   <= idx_i;
          sram_q  <= sram_i;
        end
      end
    end
  end

  p_vld_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (vld_q == '0));
  p_sram_upper_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && commit_sram_o) |-> (commit_data_o[WIDE_W-1:64] == '0));
  p_sram_lanes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_q |-> (vld_q[3:2] == 2'b00));
endmodule

// File: rtl/wrc_shadow.sv
module wrc_shadow
  import wrc_pkg::*;
#(
  parameter int unsigned IDX_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  region_e           region_i,
  input  logic              qword_i,
  input  logic [1:0]        lane_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WIDE_W-1:0] rd_data_i,
  input  logic              fwd_i,
  input  logic              fwd_sram_i,
  input  logic [IDX_W-1:0]  fwd_index_i,
  input  logic [WIDE_W-1:0] fwd_data_i,
  output logic              rd_valid_o,
  output logic [63:0]       rd_data_o
);
  logic [WIDE_W-1:0] shadow_q, src;
  logic [63:0]       nxt;
  logic              hit, load;

  always_comb begin
    // a commit leaving this cycle is not yet visible on rd_data_i
    hit  = fwd_i && (fwd_index_i == idx_i) && (fwd_sram_i == (region_i == RG_SRAM));
    src  = hit ? fwd_data_i : rd_data_i;
    load = rd_i && (region_i == RG_WIDE) && (lane_i == 2'd0);
    unique case (region_i)
      RG_WIDE:
        if (qword_i)            nxt = lane_i[1] ? shadow_q[127:64] : src[63:0];
        else if (lane_i == 2'd0) nxt = {32'h0, src[31:0]};
        else                     nxt = {32'h0, shadow_q[DW_W*lane_i +: DW_W]};
      RG_SRAM:
        if (qword_i) nxt = src[63:0];
        else         nxt = {32'h0, lane_i[0] ? src[63:32] : src[31:0]};
      RG_DWREG: nxt = {32'h0, src[31:0]};
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q   <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_i) rd_data_o <= nxt;
      if (load) shadow_q <= src;
    end
  end

  p_rd_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_i));
endmodule

// File: rtl/wreg_collector.sv
module wreg_collector
  import wrc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned OFS_EVQ    = 'h400,
  parameter int unsigned OFS_RX     = 'h800,
  parameter int unsigned OFS_TX     = 'hC00,
  parameter int unsigned IDX_W      = ADDR_W - 4,
  parameter int unsigned PG_W       = ADDR_W - 1 - PAGE_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_qword_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [63:0]       req_wdata_i,
  output logic [IDX_W-1:0]  rd_index_o,
  output logic              rd_sram_o,
  input  logic [127:0]      rd_data_i,
  output logic              rd_valid_o,
  output logic [63:0]       rd_data_o,
  output logic              commit_o,
  output logic              commit_sram_o,
  output logic [IDX_W-1:0]  commit_index_o,
  output logic [127:0]      commit_data_o,
  output logic              dw_we_o,
  output logic [1:0]        dw_sel_o,
  output logic [PG_W-1:0]   dw_page_o,
  output logic [31:0]       dw_data_o
);
  region_e          region;
  logic [1:0]       lane, sel;
  logic [IDX_W-1:0] idx;
  logic [PG_W-1:0]  page;
  logic             wr_any, rd_any, wr_stage;

  wrc_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .OFS_EVQ(OFS_EVQ),
    .OFS_RX(OFS_RX), .OFS_TX(OFS_TX), .IDX_W(IDX_W), .PG_W(PG_W)
  ) i_decode (
    .addr_i(req_addr_i), .qword_i(req_qword_i), .region_o(region),
    .lane_o(lane), .idx_o(idx), .page_o(page), .dw_sel_o(sel)
  );

  assign wr_any   = req_valid_i && req_write_i;
  assign rd_any   = req_valid_i && !req_write_i;
  assign wr_stage = wr_any && (region == RG_WIDE || region == RG_SRAM);
  assign rd_index_o = idx;
  assign rd_sram_o  = (region == RG_SRAM);

  wrc_stage #(.IDX_W(IDX_W)) i_stage (
    .clk_i, .rst_ni, .wr_i(wr_stage), .sram_i(region == RG_SRAM),
    .qword_i(req_qword_i), .lane_i(lane), .idx_i(idx), .wdata_i(req_wdata_i),
    .commit_o, .commit_sram_o, .commit_index_o, .commit_data_o
  );

  wrc_shadow #(.IDX_W(IDX_W)) i_shadow (
    .clk_i, .rst_ni, .rd_i(rd_any), .region_i(region), .qword_i(req_qword_i),
    .lane_i(lane), .idx_i(idx), .rd_data_i,
    .fwd_i(commit_o), .fwd_sram_i(commit_sram_o), .fwd_index_i(commit_index_o),
    .fwd_data_i(commit_data_o), .rd_valid_o, .rd_data_o
  );

  // designated registers: straight through, collector untouched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dw_we_o   <= 1'b0;
      dw_sel_o  <= '0;
      dw_page_o <= '0;
      dw_data_o <= '0;
    end else begin
      dw_we_o <= wr_any && (region == RG_DWREG);
      if (wr_any && region == RG_DWREG) begin
        dw_sel_o  <= sel;
        dw_page_o <= page;
        dw_data_o <= req_wdata_i[31:0];
      end
    end
  end

  p_one_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && dw_we_o));
endmodule

// File: tb/test_wreg_collector.sv
module test_wreg_collector;
  localparam int CLK_P = 10;
  localparam int AW = 20;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         req_valid = 0, req_write = 0, req_qword = 0;
  logic [19:0]  req_addr = '0;
  logic [63:0]  req_wdata = '0;
  logic [127:0] rd_data = '0;
  logic [15:0]  rd_index;
  logic         rd_sram, rd_valid, commit, commit_sram, dw_we;
  logic [63:0]  rd_out;
  logic [15:0]  commit_index;
  logic [127:0] commit_data;
  logic [1:0]   dw_sel;
  logic [5:0]   dw_page;
  logic [31:0]  dw_data;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  wreg_collector i_wreg_collector (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_qword_i(req_qword), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_index_o(rd_index), .rd_sram_o(rd_sram), .rd_data_i(rd_data),
    .rd_valid_o(rd_valid), .rd_data_o(rd_out), .commit_o(commit),
    .commit_sram_o(commit_sram), .commit_index_o(commit_index),
    .commit_data_o(commit_data), .dw_we_o(dw_we), .dw_sel_o(dw_sel),
    .dw_page_o(dw_page), .dw_data_o(dw_data)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] wa(int idx, int lane);
    return 20'((idx << 4) | (lane << 2));
  endfunction
  function automatic logic [19:0] sa(int idx, int lane);
    return 20'((1 << 19) | (idx << 3) | (lane << 2));
  endfunction
  function automatic logic [19:0] da(int page, int sel);
    return 20'((page << 13) | ('h400 * (sel + 1)));
  endfunction
  function automatic logic [31:0] pat(int idx, int w, int salt);
    return (32'(idx) * 32'h9E3779B1) ^ 32'(w * 32'h11110000 + salt);
  endfunction
  function automatic logic [127:0] pv(int idx, int salt);
    return {pat(idx,3,salt), pat(idx,2,salt), pat(idx,1,salt), pat(idx,0,salt)};
  endfunction

  // drive at a negedge, return at the next negedge (outputs then reflect the request)
  task automatic req(input logic w, input logic q, input logic [19:0] a,
                     input logic [63:0] d, input logic [127:0] bus);
    req_valid = 1'b1; req_write = w; req_qword = q; req_addr = a;
    req_wdata = d; rd_data = bus;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wide_lanes(input int idx, input int salt, input int first, input int lastl);
    for (int l = first; l <= lastl; l++) begin
      req(1'b1, 1'b0, wa(idx, l), {32'h0, pat(idx, l, salt)}, '0);
      if (l != 3) chk("R1 no commit on lower word", 128'(commit), 128'(0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset commit", 128'(commit), 0);
    chk("R11 reset dw_we", 128'(dw_we), 0);
    chk("R11 reset rd_valid", 128'(rd_valid), 0);
    chk("R11 reset rd_data", 128'(rd_out), 0);
    rst_n = 1'b1;
    idle();

    // R1: dword collection sweep across pages and slots
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 4; s++) begin
        int idx;
        int slots [4] = '{1, 'h3F, 'h100, 'h1FF};
        idx = p * 512 + slots[s];
        wide_lanes(idx, 7, 0, 3);
        chk("R1 commit strobe", 128'(commit), 1);
        chk("R1 commit sram flag", 128'(commit_sram), 0);
        chk("R1 commit index", 128'(commit_index), 128'(idx));
        chk("R1 commit data", commit_data, pv(idx, 7));
        idle();
        chk("R1 strobe one cycle", 128'(commit), 0);
      end
    end

    // R2: qword collection
    for (int i = 0; i < 6; i++) begin
      int idx;
      idx = 5 + i * 1000;
      req(1'b1, 1'b1, wa(idx, 0), {pat(idx,1,3), pat(idx,0,3)}, '0);
      chk("R2 no commit on low qword", 128'(commit), 0);
      req(1'b1, 1'b1, wa(idx, 2), {pat(idx,3,3), pat(idx,2,3)}, '0);
      chk("R2 commit on high qword", 128'(commit), 1);
      chk("R2 commit data", commit_data, pv(idx, 3));
      chk("R2 commit index", 128'(commit_index), 128'(idx));
    end

    // R3: unwritten words commit as zero; index change restarts
    wide_lanes(77, 9, 1, 1);
    wide_lanes(77, 9, 3, 3);
    chk("R3 sparse commit", commit_data, {pat(77,3,9), 32'h0, pat(77,1,9), 32'h0});
    wide_lanes(40, 2, 0, 1);
    wide_lanes(41, 2, 2, 3);
    chk("R3 restart index", 128'(commit_index), 128'(41));
    chk("R3 restart data", commit_data, {pat(41,3,2), pat(41,2,2), 64'h0});

    // R4: buffer-table entries
    for (int i = 0; i < 5; i++) begin
      int sidx;
      int list [5] = '{0, 1, 5, 'h7FFF, 'hFFFF};
      sidx = list[i];
      req(1'b1, 1'b0, sa(sidx, 0), {32'h0, pat(sidx,0,4)}, '0);
      chk("R4 no commit on low dword", 128'(commit), 0);
      req(1'b1, 1'b0, sa(sidx, 1), {32'h0, pat(sidx,1,4)}, '0);
      chk("R4 commit strobe", 128'(commit), 1);
      chk("R4 sram flag", 128'(commit_sram), 1);
      chk("R4 index", 128'(commit_index), 128'(sidx));
      chk("R4 data dwords", commit_data, {64'h0, pat(sidx,1,4), pat(sidx,0,4)});
      req(1'b1, 1'b1, sa(sidx, 0), {pat(sidx,1,6), pat(sidx,0,6)}, '0);
      chk("R4 qword commit", commit_data, {64'h0, pat(sidx,1,6), pat(sidx,0,6)});
      chk("R4 qword sram flag", 128'(commit_sram), 1);
    end

    // R5: designated registers in every page
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 3; s++) begin
        req(1'b1, 1'b0, da(p, s), {32'hFFFF_FFFF, pat(p, s, 1)}, '0);
        chk("R5 dw strobe", 128'(dw_we), 1);
        chk("R5 dw code", 128'(dw_sel), 128'(s));
        chk("R5 dw page", 128'(dw_page), 128'(p));
        chk("R5 dw data", 128'(dw_data), 128'(pat(p, s, 1)));
        chk("R5 no commit", 128'(commit), 0);
      end
    end
    idle();
    chk("R5 strobe one cycle", 128'(dw_we), 0);

    // R6: designated writes inside an open collection
    wide_lanes(300, 5, 0, 1);
    req(1'b1, 1'b0, da(0, 1), 64'h1234, '0);
    chk("R6 dw strobe mid collection", 128'(dw_we), 1);
    chk("R6 no commit mid collection", 128'(commit), 0);
    wide_lanes(300, 5, 2, 2);
    req(1'b1, 1'b0, da(3, 2), 64'h5678, '0);
    chk("R6 dw data mid collection", 128'(dw_data), 128'(32'h5678));
    wide_lanes(300, 5, 3, 3);
    chk("R6 commit intact", commit_data, pv(300, 5));
    chk("R6 commit index", 128'(commit_index), 128'(300));

    // R7: ignored writes do not touch staging or strobes
    wide_lanes(500, 8, 0, 2);
    begin
      logic [19:0] bad [5];
      logic        bq  [5];
      bad[0] = wa(500, 3) | 20'h1;  bq[0] = 1'b0;
      bad[1] = da(2, 0) | 20'h4;    bq[1] = 1'b0;
      bad[2] = da(2, 1);            bq[2] = 1'b1;
      bad[3] = wa(500, 1);          bq[3] = 1'b1;
      bad[4] = sa(9, 1);            bq[4] = 1'b1;
      for (int k = 0; k < 5; k++) begin
        req(1'b1, bq[k], bad[k], 64'hDEAD_BEEF_DEAD_BEEF, '0);
        chk("R7 ignored no commit", 128'(commit), 0);
        chk("R7 ignored no dw strobe", 128'(dw_we), 0);
      end
    end
    wide_lanes(500, 8, 3, 3);
    chk("R7 staging untouched", commit_data, pv(500, 8));

    // R8: shadow consistency
    req_valid = 1'b1; req_write = 1'b0; req_qword = 1'b0; req_addr = wa(600, 0);
    #1;
    chk("R8 read index", 128'(rd_index), 128'(600));
    chk("R8 read sram flag", 128'(rd_sram), 0);
    req(1'b0, 1'b0, wa(600, 0), '0, pv(600, 11));
    chk("R8 rd_valid", 128'(rd_valid), 1);
    chk("R8 dword0", 128'(rd_out), 128'(pat(600,0,11)));
    for (int l = 1; l < 4; l++) begin
      req(1'b0, 1'b0, wa(600, l), '0, pv(600, 99));
      chk("R8 dword from shadow", 128'(rd_out), 128'(pat(600,l,11)));
    end
    req(1'b0, 1'b1, wa(601, 0), '0, pv(601, 12));
    chk("R8 qword0", 128'(rd_out), 128'(pv(601,12)) & 128'(64'hFFFF_FFFF_FFFF_FFFF));
    req(1'b0, 1'b1, wa(601, 2), '0, pv(601, 55));
    chk("R8 qword1 from shadow", 128'(rd_out), pv(601,12) >> 64);

    // R9: shadow load in the commit cycle of the same register
    wide_lanes(700, 13, 0, 3);
    chk("R9 commit visible", 128'(commit), 1);
    req(1'b0, 1'b0, wa(700, 0), '0, pv(700, 0));
    chk("R9 forwarded dword0", 128'(rd_out), 128'(pat(700,0,13)));
    req(1'b0, 1'b0, wa(700, 3), '0, pv(700, 0));
    chk("R9 forwarded dword3", 128'(rd_out), 128'(pat(700,3,13)));
    wide_lanes(701, 14, 0, 3);
    req(1'b0, 1'b0, wa(702, 0), '0, pv(702, 21));
    chk("R9 other index uses bus", 128'(rd_out), 128'(pat(702,0,21)));

    // R10: direct reads and latency
    req_valid = 1'b1; req_write = 1'b0; req_qword = 1'b0; req_addr = sa(33, 1);
    #1;
    chk("R10 sram read index", 128'(rd_index), 128'(33));
    chk("R10 sram read flag", 128'(rd_sram), 1);
    req(1'b0, 1'b0, sa(33, 1), '0, pv(33, 2));
    chk("R10 sram dword1", 128'(rd_out), 128'(pat(33,1,2)));
    req(1'b0, 1'b1, sa(34, 0), '0, pv(34, 2));
    chk("R10 sram qword", 128'(rd_out), {64'h0, pat(34,1,2), pat(34,0,2)});
    req(1'b0, 1'b0, da(4, 2), '0, pv(3, 3));
    chk("R10 dword register read", 128'(rd_out), 128'(pat(3,0,3)));
    req(1'b0, 1'b0, wa(5, 1) | 20'h2, '0, pv(5, 3));
    chk("R10 ignored read valid", 128'(rd_valid), 1);
    chk("R10 ignored read zero", 128'(rd_out), 0);
    idle();
    chk("R10 valid one cycle", 128'(rd_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule